// File: doc/BRIEF.md
# Single-Clock FIFO with Show-Ahead Option

This block is a first-in-first-out buffer on one clock. Words enter through a write request with its data, and leave through a read request. The block reports when it is full or empty, raises two early-warning flags against programmable thresholds, and gives the number of words it holds. A parameter selects how reads behave. In normal mode a read request is a command, and the word appears on the output on the next clock. In show-ahead mode the oldest word is always presented while the buffer holds data, and a read request acts as an acknowledge that moves the output on to the next word.

Occupancy is tracked by a three-state machine with the states `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`. Its transitions are:
- first word: `OCC_EMPTY` to `OCC_PART` on a lone accepted write.
- fill up: `OCC_PART` to `OCC_FULL` on a lone write when one slot is free.
- drain out: `OCC_PART` to `OCC_EMPTY` on a lone read of the last word.
- free slot: `OCC_FULL` to `OCC_PART` on a lone accepted read.
- clear: any state to `OCC_EMPTY` on either clear.

Protection against writing into a full buffer and against reading from an empty one can each be enabled. A further option accepts a write and a read in the same cycle while full. A synchronous clear and an asynchronous clear both empty the buffer. The registered normal-mode output keeps its last value through either clear.

Top module: `ahead_fifo`

## Requirements
- R1: In normal mode (SHOW_AHEAD=0), an accepted read loads the oldest word onto `rd_data` at the clock edge where the read is sampled, so it can be observed one cycle after the request.
- R2: In show-ahead mode (SHOW_AHEAD=1), `rd_data` carries the oldest stored word whenever `empty` is low, with no request. An accepted read moves it to the next word after one clock.
- R3: With overflow protection on, a write request while `full` is high is dropped when no read is accepted in the same cycle. Contents and count stay unchanged.
- R4: With underflow protection on, a read request while `empty` is high is ignored. The count stays 0, and the normal-mode `rd_data` keeps its value.
- R5: With the read-while-full option on (it needs overflow protection), a write and a read in the same cycle while full are both accepted, and `full` stays high.
- R6: `used_cnt` is one bit wider than the address and reads DEPTH when full. It changes one clock after an accepted request: +1 for a write alone, -1 for a read alone, and no change for both.
- R7: `full` and `empty` update one clock after the request that changes them. `full` is high exactly at count DEPTH and `empty` exactly at count 0.
- R8: `almost_full` is high when `used_cnt` >= AF_LEVEL.
- R9: `almost_empty` is high when `used_cnt` < AE_LEVEL.
- R10: `sclr` high at a clock edge empties the buffer at that edge: count 0, `empty` and `almost_empty` high, `full` and `almost_full` low. It takes priority over requests in the same cycle.
- R11: `aclr` high empties the buffer at once, without waiting for a clock edge, and holds it empty while high.
- R12: In normal mode, `rd_data` changes only on an accepted read. It keeps its value through both clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| aclr | input | 1 | Asynchronous clear, active high |
| sclr | input | 1 | Synchronous clear, active high |
| wr_req | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| rd_req | input | 1 | Read request (acknowledge in show-ahead mode) |
| rd_data | output | DW | Output word |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| almost_full | output | 1 | Count at or above AF_LEVEL |
| almost_empty | output | 1 | Count below AE_LEVEL |
| used_cnt | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
A pointer that slips shows up as a wrong word on the output at the next accepted read in normal mode. In show-ahead mode it shows up at once, on the presented head word. A state machine that diverges from the counter makes `full` or `empty` disagree with `used_cnt` one clock after the request that caused it. Two instances, one per read mode, are driven with the same stimulus and compared every cycle against a queue model. This exposes any mismatch in flags, count or data within the cycle after the offending request.

// File: rtl/ahead_fifo_pkg.sv
package ahead_fifo_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;
endpackage

// File: rtl/ahead_fifo_ctrl.sv
module ahead_fifo_ctrl
    import ahead_fifo_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter bit OVF_GUARD    = 1'b1,
    parameter bit UNF_GUARD    = 1'b1,
    parameter bit WR_WHEN_FULL = 1'b0,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          aclr,
    input  logic          sclr,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] used_cnt,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE_LEFT  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE_WORD  = CW'(1);

    occ_e state, nxt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_ADDR) ? '0 : p + 1'b1;
    endfunction

    // Request acceptance, gated by the protection options
    always_comb begin
        rd_ok = rd_req & (~empty | ~UNF_GUARD);
        wr_ok = wr_req & (~full | ~OVF_GUARD | (WR_WHEN_FULL & rd_ok));
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            OCC_EMPTY: begin
                if (wr_ok && !rd_ok) nxt = OCC_PART;          // first word
            end
            OCC_PART: begin
                if (wr_ok && !rd_ok && used_cnt == ONE_LEFT)
                    nxt = OCC_FULL;                           // fill up
                else if (rd_ok && !wr_ok && used_cnt == ONE_WORD)
                    nxt = OCC_EMPTY;                          // drain out
            end
            OCC_FULL: begin
                if (rd_ok && !wr_ok) nxt = OCC_PART;          // free slot
            end
            default: nxt = OCC_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge aclr) begin
        if (aclr)      state <= OCC_EMPTY;
        else if (sclr) state <= OCC_EMPTY;
        else           state <= nxt;
    end

    // Flag outputs decoded from the state
    always_comb begin
        full  = (state == OCC_FULL);
        empty = (state == OCC_EMPTY);
    end

    // Pointers and word count
    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            used_cnt <= '0;
        end else if (sclr) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            used_cnt <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            used_cnt <= used_cnt + CW'(wr_ok) - CW'(rd_ok);
        end
    end
endmodule

// File: rtl/ahead_fifo_store.sv
module ahead_fifo_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(i)) cells[i] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/ahead_fifo_out.sv
module ahead_fifo_out #(
    parameter int DW         = 8,
    parameter bit SHOW_AHEAD = 1'b0
) (
    input  logic          clk,
    input  logic          load,
    input  logic [DW-1:0] head,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] held;

    // Registered word for normal mode; not cleared, so it survives both clears
    always_ff @(posedge clk) begin
        if (load) held <= head;
    end

    assign rd_data = SHOW_AHEAD ? head : held;
endmodule

// File: rtl/ahead_fifo.sv
module ahead_fifo #(
    parameter int DW           = 8,
    parameter int DEPTH        = 16,
    parameter int AF_LEVEL     = 12,
    parameter int AE_LEVEL     = 4,
    parameter bit SHOW_AHEAD   = 1'b0,
    parameter bit OVF_GUARD    = 1'b1,
    parameter bit UNF_GUARD    = 1'b1,
    parameter bit WR_WHEN_FULL = 1'b0,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          aclr,
    input  logic          sclr,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty,
    output logic [CW-1:0] used_cnt
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [DW-1:0] head;

    ahead_fifo_ctrl #(
        .DEPTH(DEPTH), .OVF_GUARD(OVF_GUARD),
        .UNF_GUARD(UNF_GUARD), .WR_WHEN_FULL(WR_WHEN_FULL)
    ) ctrl_i (
        .clk(clk), .aclr(aclr), .sclr(sclr),
        .wr_req(wr_req), .rd_req(rd_req),
        .wr_ok(wr_ok), .rd_ok(rd_ok),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .used_cnt(used_cnt), .full(full), .empty(empty)
    );

    ahead_fifo_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
        .clk(clk), .we(wr_ok & ~sclr & ~aclr), .waddr(wr_ptr),
        .wdata(wr_data), .raddr(rd_ptr), .rdata(head)
    );

    ahead_fifo_out #(.DW(DW), .SHOW_AHEAD(SHOW_AHEAD)) out_i (
        .clk(clk), .load(rd_ok & ~sclr & ~aclr),
        .head(head), .rd_data(rd_data)
    );

    always_comb begin
        almost_full  = (used_cnt >= CW'(AF_LEVEL));
        almost_empty = (used_cnt <  CW'(AE_LEVEL));
    end
endmodule

// File: rtl/ahead_fifo_chk.sv
module ahead_fifo_chk #(
    parameter int DW           = 8,
    parameter int DEPTH        = 16,
    parameter bit SHOW_AHEAD   = 1'b0,
    parameter bit OVF_GUARD    = 1'b1,
    parameter bit UNF_GUARD    = 1'b1,
    parameter bit WR_WHEN_FULL = 1'b0,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          aclr,
    input logic          sclr,
    input logic          wr_req,
    input logic          rd_req,
    input logic [DW-1:0] rd_data,
    input logic          full,
    input logic          empty,
    input logic          almost_full,
    input logic          almost_empty,
    input logic [CW-1:0] used_cnt
);
    logic loaded;
    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) loaded <= 1'b0;
        else if (rd_req && !empty && !sclr) loaded <= 1'b1;
    end

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (aclr)
        !(full && empty));

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (aclr)
        used_cnt <= CW'(DEPTH));

    assert_empty_matches_count_R7: assert property (@(posedge clk) disable iff (aclr)
        empty == (used_cnt == '0));

    assert_full_matches_count_R7: assert property (@(posedge clk) disable iff (aclr)
        full == (used_cnt == CW'(DEPTH)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (aclr)
        (OVF_GUARD && !sclr && full && wr_req && !rd_req) |=> (full && used_cnt == CW'(DEPTH)));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (aclr)
        (UNF_GUARD && !sclr && empty && rd_req && !wr_req) |=> (empty && used_cnt == '0));

    assert_rw_when_full_R5: assert property (@(posedge clk) disable iff (aclr)
        (WR_WHEN_FULL && OVF_GUARD && !sclr && full && wr_req && rd_req) |=> full);

    assert_sync_clear_R10: assert property (@(posedge clk) disable iff (aclr)
        sclr |=> (empty && !full && used_cnt == '0 && almost_empty && !almost_full));

    assert_async_clear_R11: assert property (@(posedge clk)
        aclr |-> (empty && !full && used_cnt == '0));

    assert_output_hold_R12: assert property (@(posedge clk) disable iff (aclr)
        (!SHOW_AHEAD && loaded && !(rd_req && !empty)) |=> $stable(rd_data));
endmodule

bind ahead_fifo ahead_fifo_chk #(
    .DW(DW), .DEPTH(DEPTH), .SHOW_AHEAD(SHOW_AHEAD), .OVF_GUARD(OVF_GUARD),
    .UNF_GUARD(UNF_GUARD), .WR_WHEN_FULL(WR_WHEN_FULL)
) chk_i (
    .clk(clk), .aclr(aclr), .sclr(sclr), .wr_req(wr_req), .rd_req(rd_req),
    .rd_data(rd_data), .full(full), .empty(empty), .almost_full(almost_full),
    .almost_empty(almost_empty), .used_cnt(used_cnt)
);

// File: tb/ahead_fifo_tb_top.sv
module ahead_fifo_tb_top;
    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int AFL   = 6;
    localparam int AEL   = 2;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          aclr = 1'b1, sclr = 1'b0, wr_req = 1'b0, rd_req = 1'b0;
    logic [DW-1:0] wr_data = '0;

    logic [DW-1:0] n_q, s_q;
    logic          n_full, n_empty, n_af, n_ae, s_full, s_empty, s_af, s_ae;
    logic [CW-1:0] n_cnt, s_cnt;

    ahead_fifo #(.DW(DW), .DEPTH(DEPTH), .AF_LEVEL(AFL), .AE_LEVEL(AEL),
                 .SHOW_AHEAD(1'b0), .WR_WHEN_FULL(1'b1)) dut_i (
        .clk(clk), .aclr(aclr), .sclr(sclr), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(n_q), .full(n_full), .empty(n_empty),
        .almost_full(n_af), .almost_empty(n_ae), .used_cnt(n_cnt));

    ahead_fifo #(.DW(DW), .DEPTH(DEPTH), .AF_LEVEL(AFL), .AE_LEVEL(AEL),
                 .SHOW_AHEAD(1'b1), .WR_WHEN_FULL(1'b1)) dut_sa_i (
        .clk(clk), .aclr(aclr), .sclr(sclr), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(s_q), .full(s_full), .empty(s_empty),
        .almost_full(s_af), .almost_empty(s_ae), .used_cnt(s_cnt));

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [$];
    logic [DW-1:0] last_q = '0;
    bit q_known = 1'b0;

    task automatic chk_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_af(input int n); return (n >= AFL) ? 1 : 0; endfunction
    function automatic int exp_ae(input int n); return (n < AEL) ? 1 : 0; endfunction

    task automatic compare_all();
        int sz;
        sz = model.size();
        chk_eq("R6", "normal count", int'(n_cnt), sz);
        chk_eq("R6", "ahead count", int'(s_cnt), sz);
        chk_eq("R7", "normal full", int'(n_full), int'(sz == DEPTH));
        chk_eq("R7", "ahead full", int'(s_full), int'(sz == DEPTH));
        chk_eq("R7", "normal empty", int'(n_empty), int'(sz == 0));
        chk_eq("R7", "ahead empty", int'(s_empty), int'(sz == 0));
        chk_eq("R8", "normal almost_full", int'(n_af), exp_af(sz));
        chk_eq("R8", "ahead almost_full", int'(s_af), exp_af(sz));
        chk_eq("R9", "normal almost_empty", int'(n_ae), exp_ae(sz));
        chk_eq("R9", "ahead almost_empty", int'(s_ae), exp_ae(sz));
        if (q_known) chk_eq("R1", "normal data", int'(n_q), int'(last_q));
        if (sz > 0)  chk_eq("R2", "ahead head word", int'(s_q), int'(model[0]));
    endtask

    task automatic step(input bit w, input bit r, input bit s, input logic [DW-1:0] d);
        int  sz;
        bit  rok, wok;
        @(negedge clk);
        wr_req = w; rd_req = r; sclr = s; wr_data = d;
        @(posedge clk);
        if (s) begin
            model.delete();
        end else begin
            sz  = model.size();
            rok = r && (sz > 0);
            wok = w && ((sz < DEPTH) || rok);
            if (rok) begin
                last_q  = model.pop_front();
                q_known = 1'b1;
            end
            if (wok) model.push_back(d);
        end
        #1;
        compare_all();
    endtask

    task automatic async_clear();
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0; sclr = 1'b0;
        #2 aclr = 1'b1;
        #1;
        chk_eq("R11", "normal empty at aclr", int'(n_empty), 1);
        chk_eq("R11", "ahead empty at aclr", int'(s_empty), 1);
        chk_eq("R11", "normal count at aclr", int'(n_cnt), 0);
        chk_eq("R11", "ahead full at aclr", int'(s_full), 0);
        if (q_known) chk_eq("R12", "normal data kept at aclr", int'(n_q), int'(last_q));
        model.delete();
        @(negedge clk);
        aclr = 1'b0;
        #1;
        compare_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F1F0));
        // reset state under aclr
        repeat (2) @(posedge clk);
        #1;
        chk_eq("R11", "normal empty in reset", int'(n_empty), 1);
        chk_eq("R11", "normal count in reset", int'(n_cnt), 0);
        chk_eq("R9", "almost_empty in reset", int'(n_ae), 1);
        chk_eq("R8", "almost_full in reset", int'(s_af), 0);
        @(negedge clk);
        aclr = 1'b0;

        // read from empty is ignored (R4)
        step(1'b0, 1'b1, 1'b0, 8'h00);
        chk_eq("R4", "count after read on empty", int'(n_cnt), 0);
        chk_eq("R4", "empty after read on empty", int'(s_empty), 1);

        // fill to full
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'b0, DW'(8'h10 + i));
        chk_eq("R6", "count at full", int'(n_cnt), DEPTH);

        // write while full is dropped (R3)
        step(1'b1, 1'b0, 1'b0, 8'hEE);
        chk_eq("R3", "count after write on full", int'(n_cnt), DEPTH);
        chk_eq("R3", "full after write on full", int'(s_full), 1);

        // read and write together while full (R5)
        step(1'b1, 1'b1, 1'b0, 8'hA5);
        chk_eq("R5", "full kept on read+write", int'(n_full), 1);
        chk_eq("R5", "normal data on read+write", int'(n_q), 8'h10);

        // drain completely, one extra read on empty
        for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 1'b1, 1'b0, 8'h00);
        chk_eq("R4", "normal data held after read on empty", int'(n_q), 8'hA5);

        // simultaneous read and write in middle leaves count
        step(1'b1, 1'b0, 1'b0, 8'h31);
        step(1'b1, 1'b0, 1'b0, 8'h32);
        step(1'b1, 1'b1, 1'b0, 8'h33);
        chk_eq("R6", "count unchanged on read+write", int'(s_cnt), 2);

        // synchronous clear with a pending read and write (R10, R12)
        step(1'b1, 1'b1, 1'b1, 8'h77);
        chk_eq("R10", "empty after sclr", int'(n_empty), 1);
        chk_eq("R10", "count after sclr", int'(s_cnt), 0);
        chk_eq("R12", "normal data kept at sclr", int'(n_q), int'(last_q));

        // random phases with different biases
        for (int ph = 0; ph < 4; ph++) begin
            for (int c = 0; c < 400; c++) begin
                int wp, rp;
                bit w, r, s;
                wp = (ph == 0) ? 80 : (ph == 1) ? 30 : 55;
                rp = (ph == 0) ? 30 : (ph == 1) ? 80 : 55;
                w = ($urandom % 100) < wp;
                r = ($urandom % 100) < rp;
                s = (ph == 3) && (($urandom % 64) == 0);
                step(w, r, s, DW'($urandom));
            end
            if (ph == 2) async_clear();
        end

        // refill partway, then asynchronous clear
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, DW'(8'h50 + i));
        async_clear();
        step(1'b1, 1'b0, 1'b0, 8'h9C);
        chk_eq("R2", "head word after write to empty", int'(s_q), 8'h9C);
        step(1'b0, 1'b1, 1'b0, 8'h00);
        chk_eq("R1", "normal data after single read", int'(n_q), 8'h9C);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule